// File: doc/BRIEF.md
# Calibration Step Sequencer

This block schedules a series of calibration steps that a host selects by setting bits in two 8-bit request registers. The host loads the second request register first, then writes the first request register with its start bit set. That write latches the whole request set and launches the run. The sequencer takes the selected steps one at a time, highest bit first. For each step it raises that step's enable and waits until the step ends. A step ends when the enable has been held for a fixed count, when the step reports done, or when a failure, a timeout or a hook-state change cuts it short.

Each request bit drops as soon as its step is finished. The start bit drops last, and at that point the block raises a one-cycle completion pulse, so the first request register reading zero means the run is over. Any failure clears every outstanding request, returns the sequencer to idle and sets a sticky error flag in an interrupt status register. That flag drives the interrupt pin only when the matching enable bit is set. The analog calibration work sits outside this block and is represented only by its done, error and off-hook inputs.

Top module: `cal_seq`

## Requirements
- R1: After reset all four registers read 0x00, and step_en, seq_done and irq are all low.
- R2: Registers are selected by address: 0 is the first request register (A), 1 is the second request register (B), 2 is the interrupt status, 3 is the interrupt enable. While the block is idle, a write to address 0 with bit 7 = 1 and bit 6 = 0 latches A[7] and A[5:0], keeps B as last written, and starts a run. An idle write to address 0 with bit 7 = 0 changes nothing.
- R3: Bit 6 of A always reads 0. A write to A with bit 6 = 1 is ignored entirely: A keeps its value and no step runs.
- R4: The requests form a 14-bit set {A[5:0], B[7:0]}, where set bit i drives step_en[i]. Steps run one at a time in descending i, with step_en one-hot or zero and low for at least one cycle between steps.
- R5: Each request bit clears when its step finishes. Once no requests remain, A[7] clears, A reads 0x00 and seq_done pulses high for one cycle.
- R6: The two leakage steps (i = 13 and 12, that is A bits 5 and 4) each hold their enable for exactly LEAK_CYC cycles and ignore step_done.
- R7: Every other step finishes on step_done. If step_done has not arrived after TMO_CYC cycles of enable, the step fails.
- R8: When off_hook is high during step 0 (the common-mode balance step, B bit 0), the run aborts with an error. off_hook has no effect during any other step.
- R9: On any failure (step_err high during a step, a timeout or an off-hook abort), A and B clear to 0x00, step_en drops, the sequencer returns to idle and status bit 7 is set.
- R10: Status bit 7 is sticky. It clears only on a write to address 2 with bit 7 = 1; writing 0 there leaves it set.
- R11: irq is high exactly when status bit 7 and enable bit 7 are both set.
- R12: While a run is in progress, writes to A and B are ignored, and A reads back the values latched at start (with finished bits cleared).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| step_en | output | 14 | Per-step enable, one-hot while a step runs |
| step_done | input | 1 | Active step has finished |
| step_err | input | 1 | Active step has failed |
| off_hook | input | 1 | Line hook-state indication |
| seq_done | output | 1 | One-cycle pulse when a run finishes normally |
| irq | output | 1 | Masked error interrupt |

## Verification
A corrupted current-step index shows up in the next cycle as a wrong or multi-hot step_en. A stuck request bit shows up on seq_done and on the first register's read value: the pulse never arrives, or A fails to read 0x00 one cycle after the final step. A wrong step timer shows up as an enable high for the wrong number of cycles. The bench counts those cycles exactly for the leakage and timeout cases. A missed abort shows up one cycle after the triggering input, because step_en stays high and the status flag stays clear.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  localparam int NSTEP = 14;
  localparam int IDXW  = 4;

  typedef enum logic [1:0] {S_IDLE, S_PICK, S_RUN} seq_state_t;

  // The two highest step slots are fixed-duration leakage steps.
  function automatic logic is_leak(input logic [IDXW-1:0] idx);
    return (idx == IDXW'(NSTEP - 1)) || (idx == IDXW'(NSTEP - 2));
  endfunction

  // A start write must carry bit 7 and keep the reserved bit 6 clear.
  function automatic logic start_word(input logic [7:0] d);
    return d[7] && !d[6];
  endfunction

endpackage

// File: rtl/cal_pri_enc.sv
module cal_pri_enc #(
  parameter int W  = 14,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign found = |req;
endmodule

// File: rtl/cal_step_timer.sv
module cal_step_timer #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  assign expired = (cnt_q == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/cal_seq.sv
module cal_seq
  import cal_seq_pkg::*;
#(
  parameter int LEAK_CYC = 250_000,
  parameter int TMO_CYC  = 10_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [1:0]        rd_addr,
  output logic [7:0]        rd_data,
  output logic [NSTEP-1:0]  step_en,
  input  logic              step_done,
  input  logic              step_err,
  input  logic              off_hook,
  output logic              seq_done,
  output logic              irq
);
  localparam int MAXC = (LEAK_CYC > TMO_CYC) ? LEAK_CYC : TMO_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  seq_state_t      state_q;
  logic [7:0]      ctl_a_q, ctl_b_q;
  logic [IDXW-1:0] cur_q;
  logic            err_q, irq_en_q, seq_done_q;

  logic [NSTEP-1:0] req;
  logic             found;
  logic [IDXW-1:0]  pick_idx;
  logic             expired, leak_step, busy, running;
  logic [CW-1:0]    limit;
  logic             evt_timeout, evt_hook, evt_abort, evt_fin;
  logic             idle_wr_a, idle_wr_b, start_ok, clr_stat;

  assign req      = {ctl_a_q[5:0], ctl_b_q};
  assign busy     = (state_q != S_IDLE);
  assign running  = (state_q == S_RUN);

  cal_pri_enc #(.W(NSTEP), .IW(IDXW)) u_enc (
    .req(req), .found(found), .idx(pick_idx)
  );

  assign leak_step = is_leak(cur_q);
  assign limit     = leak_step ? CW'(LEAK_CYC) : CW'(TMO_CYC);

  cal_step_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart(!running), .limit(limit), .expired(expired)
  );

  // Named events for the checker.
  assign evt_timeout = running && !leak_step && expired && !step_done;
  assign evt_hook    = running && (cur_q == '0) && off_hook;
  assign evt_abort   = running && (step_err || evt_hook || evt_timeout);
  assign evt_fin     = running && !evt_abort && (leak_step ? expired : step_done);

  assign idle_wr_a = wr_en && (wr_addr == 2'd0) && !busy;
  assign idle_wr_b = wr_en && (wr_addr == 2'd1) && !busy;
  assign start_ok  = idle_wr_a && start_word(wr_data);
  assign clr_stat  = wr_en && (wr_addr == 2'd2) && wr_data[7];

  genvar g;
  generate
    for (g = 0; g < NSTEP; g++) begin : g_en
      assign step_en[g] = running && (cur_q == IDXW'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      ctl_a_q    <= '0;
      ctl_b_q    <= '0;
      cur_q      <= '0;
      seq_done_q <= 1'b0;
    end else begin
      seq_done_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (idle_wr_b) ctl_b_q <= wr_data;
          if (start_ok) begin
            ctl_a_q <= {1'b1, 1'b0, wr_data[5:0]};
            state_q <= S_PICK;
          end
        end
        S_PICK: begin
          if (found) begin
            cur_q   <= pick_idx;
            state_q <= S_RUN;
          end else begin
            ctl_a_q[7] <= 1'b0;
            seq_done_q <= 1'b1;
            state_q    <= S_IDLE;
          end
        end
        S_RUN: begin
          if (evt_abort) begin
            ctl_a_q <= '0;
            ctl_b_q <= '0;
            state_q <= S_IDLE;
          end else if (evt_fin) begin
            if (cur_q[3]) ctl_a_q[cur_q[2:0]] <= 1'b0;
            else          ctl_b_q[cur_q[2:0]] <= 1'b0;
            state_q <= S_PICK;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q    <= 1'b0;
      irq_en_q <= 1'b0;
    end else begin
      if (evt_abort)     err_q <= 1'b1;
      else if (clr_stat) err_q <= 1'b0;
      if (wr_en && (wr_addr == 2'd3)) irq_en_q <= wr_data[7];
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = ctl_a_q;
      2'd1:    rd_data = ctl_b_q;
      2'd2:    rd_data = {err_q, 7'b0};
      default: rd_data = {irq_en_q, 7'b0};
    endcase
  end

  assign seq_done = seq_done_q;
  assign irq      = err_q && irq_en_q;
endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic [7:0]  wr_data,
  input logic [1:0]  rd_addr,
  input logic [7:0]  rd_data,
  input logic [13:0] step_en,
  input logic        off_hook,
  input logic        seq_done,
  input logic        irq,
  input logic        busy,
  input logic        err_q,
  input logic [7:0]  ctl_a_q,
  input logic        evt_abort
);
  AST_EN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_en)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (step_en == '0)); // R12
  AST_RSV_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd0) |-> !rd_data[6]); // R3
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (ctl_a_q == 8'h00)); // R5
  AST_HOOK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en[0] && off_hook) |=> (err_q && !busy)); // R8
  AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    evt_abort |=> ((ctl_a_q == 8'h00) && (step_en == '0))); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(wr_en && (wr_addr == 2'd2) && wr_data[7])) |=> err_q); // R10
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> err_q); // R11
endmodule

bind cal_seq cal_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .step_en(step_en), .off_hook(off_hook),
  .seq_done(seq_done), .irq(irq), .busy(busy), .err_q(err_q), .ctl_a_q(ctl_a_q),
  .evt_abort(evt_abort)
);

// File: tb/sim_cal_seq.sv
module sim_cal_seq;
  localparam int LEAK = 6;
  localparam int TMO  = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [13:0] step_en;
  logic        step_done = 1'b0;
  logic        step_err = 1'b0;
  logic        off_hook = 1'b0;
  logic        seq_done, irq;

  int n_chk = 0, n_err = 0;
  bit resp_on = 1'b1, skip0 = 1'b0, log_clr = 1'b0;
  int order_log [16];
  int order_n = 0;
  int cycles_on [14];
  logic [13:0] prev_en = '0;
  int rc = 0;

  always #5 clk = ~clk;

  cal_seq #(.LEAK_CYC(LEAK), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .step_en(step_en), .step_done(step_done),
    .step_err(step_err), .off_hook(off_hook), .seq_done(seq_done), .irq(irq)
  );

  // Step model: logs order and enable lengths, answers non-leak steps after a delay.
  always @(negedge clk) begin
    if (log_clr) begin
      order_n = 0;
      for (int i = 0; i < 14; i++) cycles_on[i] = 0;
    end else if (step_en != '0) begin
      int ix;
      ix = 0;
      for (int i = 0; i < 14; i++) if (step_en[i]) ix = i;
      cycles_on[ix]++;
      if (step_en != prev_en && order_n < 16) begin
        order_log[order_n] = ix;
        order_n++;
      end
    end
    if (step_en != prev_en) rc = 0; else rc++;
    step_done = resp_on && (step_en != '0) && ((step_en & 14'h3000) == '0)
                && !(skip0 && step_en[0]) && (rc == 2);
    prev_en = step_en;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic clear_log();
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int k;
    k = 0;
    while (!seq_done && k < 2000) begin
      @(negedge clk); k++;
    end
    chk({tag, " completion pulse"}, int'(seq_done), 1);
    @(negedge clk);
  endtask

  localparam logic [15:0] VEC [5] = '{16'h8000, 16'hB000, 16'h8381, 16'hA124, 16'h84FF};

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); chk("R1 register reset", d, 0);
    end
    chk("R1 step_en reset", step_en, 0);
    chk("R1 irq/done reset", {irq, seq_done}, 0);

    // R2 R4 R5 R6 table of request patterns
    foreach (VEC[v]) begin
      logic [13:0] comb;
      int exp_n;
      int mism;
      comb = {VEC[v][13:8], VEC[v][7:0]};
      clear_log();
      wr(2'd1, VEC[v][7:0]);
      wr(2'd0, VEC[v][15:8]);
      wait_done("R5");
      exp_n = 0; mism = 0;
      for (int i = 13; i >= 0; i--) if (comb[i]) begin
        if (exp_n >= order_n || order_log[exp_n] != i) mism++;
        exp_n++;
      end
      chk("R4 step count", order_n, exp_n);
      chk("R4 step order mismatches", mism, 0);
      if (comb[13]) chk("R6 leak step 13 length", cycles_on[13], LEAK);
      if (comb[12]) chk("R6 leak step 12 length", cycles_on[12], LEAK);
      rd(2'd0, d); chk("R5 A reads zero at end", d, 0);
      rd(2'd1, d); chk("R5 B reads zero at end", d, 0);
      rd(2'd2, d); chk("R9 no error flag", d, 0);
    end

    // R3 reserved bit, R2 write without start
    clear_log();
    wr(2'd0, 8'hC0);
    repeat (4) @(negedge clk);
    rd(2'd0, d); chk("R3 reserved write ignored", d, 0);
    chk("R3 no step after reserved write", order_n, 0);
    wr(2'd0, 8'h3F);
    repeat (4) @(negedge clk);
    rd(2'd0, d); chk("R2 write without start ignored", d, 0);
    chk("R2 no step without start", order_n, 0);

    // R12 writes during a run
    clear_log();
    wr(2'd0, 8'hB0);
    wr(2'd0, 8'h81);
    wr(2'd1, 8'h55);
    rd(2'd1, d); chk("R12 B unchanged while busy", d, 0);
    rd(2'd0, d); chk("R12 A holds latched value", d, 8'hB0);
    wait_done("R12");
    chk("R12 only latched steps ran", order_n, 2);

    // R8 off-hook: ignored on step 1, aborts step 0; R11 irq enabled
    wr(2'd3, 8'h80);
    clear_log();
    skip0 = 1'b1; off_hook = 1'b1;
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h80);
    repeat (20) @(negedge clk);
    off_hook = 1'b0; skip0 = 1'b0;
    chk("R8 step 1 finished despite off-hook", order_n, 2);
    chk("R8 step 0 cut after one cycle", cycles_on[0], 1);
    rd(2'd2, d); chk("R8 abort sets status", d, 8'h80);
    chk("R11 irq with enable set", irq, 1);
    rd(2'd0, d); chk("R9 A cleared on abort", d, 0);
    chk("R9 step_en low after abort", step_en, 0);
    // R10 sticky, W1C
    wr(2'd2, 8'h00);
    rd(2'd2, d); chk("R10 status survives write of 0", d, 8'h80);
    wr(2'd2, 8'h80);
    rd(2'd2, d); chk("R10 status cleared by write 1", d, 0);
    chk("R11 irq low after clear", irq, 0);

    // R7 timeout with interrupt masked
    wr(2'd3, 8'h00);
    clear_log();
    resp_on = 1'b0;
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h80);
    repeat (TMO + 10) @(negedge clk);
    chk("R7 enable held for timeout length", cycles_on[1], TMO);
    rd(2'd2, d); chk("R7 timeout sets status", d, 8'h80);
    chk("R11 irq masked", irq, 0);
    rd(2'd1, d); chk("R9 B cleared on timeout", d, 0);
    wr(2'd3, 8'h80);
    chk("R11 irq after enabling", irq, 1);
    wr(2'd2, 8'h80);

    // R9 step_err on step 11 cancels pending step 4
    clear_log();
    wr(2'd1, 8'h10);
    wr(2'd0, 8'h88);
    for (int k = 0; k < 50 && !step_en[11]; k++) @(negedge clk);
    step_err = 1'b1;
    @(negedge clk);
    step_err = 1'b0;
    repeat (5) @(negedge clk);
    rd(2'd2, d); chk("R9 step error sets status", d, 8'h80);
    rd(2'd0, d); chk("R9 A cleared on step error", d, 0);
    chk("R9 pending step never ran", cycles_on[4], 0);
    resp_on = 1'b1;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule